// File: doc/BRIEF.md
# Cascaded Two-Stage Binary Counter

This block is an 8-bit up-counter built from two identical 4-bit counter stages. Each stage can clear, load and count, and it drives a terminal-count flag. The lower stage counts on every clock while the enable input is high. The upper stage has one count enable, and that enable is the lower stage's terminal-count flag. No other signal passes between the stages. Together the two stages form a modulo-256 counter. The upper stage's terminal-count flag becomes the terminal count of the whole counter, so a further counter can be chained onto this one.

Each stage picks one of four actions on every clock. The checks run in a fixed order, and the first one that matches sets the action:

| Action | When it is chosen | What the stage does |
|---|---|---|
| CLEAR | clear is high | the stage goes to zero |
| LOAD | load is high | the stage takes its slice of the data input |
| COUNT | the stage's enable is high | the stage adds one and wraps from 15 to 0 |
| HOLD | none of the above | the stage keeps its value |

The stage goes from one action to the next on every clock, according to its inputs. The action does not depend on the stage's earlier history. All changes are synchronous to the rising edge of the clock.

Top module: `cascade_ctr`

## Requirements
- R1: When `clr` is 1, `q` is 0 after the next rising edge, whatever the values of `ld` and `en`.
- R2: When `clr` is 0 and `ld` is 1, `q` takes all 8 bits of `din` in one clock. `en` has no effect on that clock, so no increment happens.
- R3: When `clr` and `ld` are both 0 and `en` is 1, `q` becomes `(q + 1) mod 256` after the next edge.
- R4: When `clr`, `ld` and `en` are all 0, `q` keeps its value.
- R5: While counting, the low nibble `q[3:0]` wraps from 4'b1111 to 4'b0000. The high nibble `q[7:4]` goes up by one on that same clock.
- R6: The high nibble `q[7:4]` does not change on a clock where `en` is 1 and `q[3:0]` is not 4'b1111. It also does not change when `en` is 0. Both apply when `clr` and `ld` are 0.
- R7: `tc` is combinational. It is 1 exactly when `q` is 8'hFF and `en` is 1.
- R8: When `q` is 8'hFF, `en` is 1 and `clr` and `ld` are 0, the next value of `q` is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter changes on the rising edge |
| clr | input | 1 | Synchronous clear; it has the highest priority |
| ld | input | 1 | Synchronous parallel load of all 8 bits |
| din | input | 8 | Value to load |
| en | input | 1 | Count enable for the low stage |
| q | output | 8 | Counter value |
| tc | output | 1 | Terminal count of the whole counter |

## Verification
The assertions assume that `clr` is driven high before anything else matters. Until the checker has seen a clear, the counter value is unknown, so every property except the clear property stays disabled. The properties also assume that `clr`, `ld`, `en` and `din` carry known values on every rising edge. The bench meets both assumptions. It holds `clr` high from time zero, and it changes every input only on the falling edge of the clock. As a result, each input is stable for half a period on each side of the sampling edge.

// File: rtl/cascade_ctr_pkg.sv
package cascade_ctr_pkg;

    // Action a counter stage takes on the coming clock edge, in priority order
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_COUNT = 2'd1,
        ACT_LOAD  = 2'd2,
        ACT_CLEAR = 2'd3
    } stage_act_e;

endpackage

// File: rtl/cascade_ctr_stage.sv
module cascade_ctr_stage
    import cascade_ctr_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         ld,
    input  logic [W-1:0] d,
    input  logic         cnt_en,
    output logic [W-1:0] q,
    output logic         tc
);

    localparam logic [W-1:0] TOP_VAL = '1;
    localparam logic [W-1:0] ONE     = W'(1);

    stage_act_e act;

    // Choose the action: clear, then load, then count, then hold
    always_comb begin
        if (clr)
            act = ACT_CLEAR;
        else if (ld)
            act = ACT_LOAD;
        else if (cnt_en)
            act = ACT_COUNT;
        else
            act = ACT_HOLD;
    end

    // State register
    always_ff @(posedge clk) begin
        unique case (act)
            ACT_CLEAR: q <= '0;
            ACT_LOAD:  q <= d;
            ACT_COUNT: q <= q + ONE;
            ACT_HOLD:  q <= q;
            default:   q <= q;
        endcase
    end

    // Terminal count: the stage is enabled and holds its largest value
    always_comb begin
        tc = cnt_en & (q == TOP_VAL);
    end

endmodule

// File: rtl/cascade_ctr.sv
module cascade_ctr #(
    parameter int STAGE_W  = 4,
    parameter int N_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        clr,
    input  logic                        ld,
    input  logic [STAGE_W*N_STAGES-1:0] din,
    input  logic                        en,
    output logic [STAGE_W*N_STAGES-1:0] q,
    output logic                        tc
);

    localparam int TOT_W = STAGE_W * N_STAGES;

    // en_chain[i] enables stage i; en_chain[i+1] is the terminal count of stage i
    logic [N_STAGES:0] en_chain;
    logic [TOT_W-1:0]  q_all;

    assign en_chain[0] = en;

    for (genvar i = 0; i < N_STAGES; i++) begin : g_stage
        cascade_ctr_stage #(
            .W (STAGE_W)
        ) u_stage (
            .clk    (clk),
            .clr    (clr),
            .ld     (ld),
            .d      (din[i*STAGE_W +: STAGE_W]),
            .cnt_en (en_chain[i]),
            .q      (q_all[i*STAGE_W +: STAGE_W]),
            .tc     (en_chain[i+1])
        );
    end

    // Output process
    always_comb begin
        q  = q_all;
        tc = en_chain[N_STAGES];
    end

endmodule

// File: rtl/cascade_ctr_checker.sv
module cascade_ctr_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         clr,
    input logic         ld,
    input logic [W-1:0] din,
    input logic         en,
    input logic [W-1:0] q,
    input logic         tc
);

    localparam int           HW      = W / 2;
    localparam logic [W-1:0] MAX_V   = '1;
    localparam logic [W-1:0] ONE_V   = W'(1);
    localparam logic [HW-1:0] LO_MAX = '1;

    // Becomes 1 after the first clear; until then q is unknown
    logic armed = 1'b0;
    always_ff @(posedge clk) armed <= armed | clr;

    // R1
    p_clear_r1: assert property (@(posedge clk)
        clr |=> (q == '0));

    // R2
    p_load_r2: assert property (@(posedge clk) disable iff (clr || !armed)
        ld |=> (q == $past(din)));

    // R3
    p_count_r3: assert property (@(posedge clk) disable iff (clr || !armed)
        (!ld && en) |=> (q == $past(q) + ONE_V));

    // R4
    p_hold_r4: assert property (@(posedge clk) disable iff (clr || !armed)
        (!ld && !en) |=> $stable(q));

    // R5
    p_carry_r5: assert property (@(posedge clk) disable iff (clr || !armed)
        (!ld && en && q[HW-1:0] == LO_MAX) |=>
            (q[HW-1:0] == '0 && q[W-1:HW] == $past(q[W-1:HW]) + HW'(1)));

    // R6
    p_upper_still_r6: assert property (@(posedge clk) disable iff (clr || !armed)
        (!ld && !(en && q[HW-1:0] == LO_MAX)) |=> $stable(q[W-1:HW]));

    // R7
    p_tc_r7: assert property (@(posedge clk) disable iff (!armed)
        tc == (en && q == MAX_V));

    // R8
    p_wrap_r8: assert property (@(posedge clk) disable iff (clr || !armed)
        (!ld && en && q == MAX_V) |=> (q == '0));

endmodule

bind cascade_ctr cascade_ctr_checker #(
    .W (STAGE_W * N_STAGES)
) u_chk (
    .clk (clk),
    .clr (clr),
    .ld  (ld),
    .din (din),
    .en  (en),
    .q   (q),
    .tc  (tc)
);

// File: tb/cascade_ctr_bench.sv
module cascade_ctr_bench;

    logic       clk = 1'b0;
    logic       clr = 1'b1;
    logic       ld  = 1'b0;
    logic [7:0] din = 8'h00;
    logic       en  = 1'b0;
    logic [7:0] q;
    logic       tc;

    int total = 0;
    int bad   = 0;
    logic [7:0] exp_q = 8'h00;

    // 50 MHz
    always #10 clk = ~clk;

    cascade_ctr u_cascade_ctr (
        .clk (clk),
        .clr (clr),
        .ld  (ld),
        .din (din),
        .en  (en),
        .q   (q),
        .tc  (tc)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock edge; returns on the falling edge after it
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Next value that the requirements give for the current inputs
    function automatic logic [7:0] model_next(input logic [7:0] cur);
        if (clr)      return 8'h00;
        else if (ld)  return din;
        else if (en)  return cur + 8'h01;
        else          return cur;
    endfunction

    task automatic clock_and_check(input string req);
        exp_q = model_next(exp_q);
        step();
        chk(req, q, exp_q);
    endtask

    task automatic t_reset();
        clr = 1'b1; ld = 1'b1; en = 1'b1; din = 8'h77;
        clock_and_check("R1 clear beats load/enable");
        clock_and_check("R1 clear held");
        chk("R7 tc low after clear", tc, 0);
        clr = 1'b0; ld = 1'b0; en = 1'b0;
    endtask

    task automatic t_load();
        ld = 1'b1; en = 1'b1; din = 8'hA5;
        clock_and_check("R2 load with en=1, no increment");
        din = 8'h3C; en = 1'b0;
        clock_and_check("R2 load with en=0");
        ld = 1'b0;
    endtask

    task automatic t_hold();
        en = 1'b0;
        for (int i = 0; i < 4; i++) clock_and_check("R4 hold with en=0");
        chk("R7 tc low while holding", tc, 0);
    endtask

    task automatic t_count_run();
        ld = 1'b1; din = 8'h10; step(); exp_q = 8'h10; ld = 1'b0;
        en = 1'b1;
        for (int i = 0; i < 40; i++) clock_and_check("R3 increment");
    endtask

    task automatic t_nibble_carry();
        ld = 1'b1; din = 8'h3D; step(); exp_q = 8'h3D; ld = 1'b0;
        en = 1'b1;
        clock_and_check("R3 to 3E");
        chk("R6 upper nibble unchanged", q[7:4], 4'h3);
        clock_and_check("R3 to 3F");
        chk("R6 upper nibble still 3", q[7:4], 4'h3);
        clock_and_check("R5 carry into upper nibble");
        chk("R5 low nibble wrapped", q[3:0], 4'h0);
        chk("R5 upper nibble stepped", q[7:4], 4'h4);
        ld = 1'b1; din = 8'h5F; step(); exp_q = 8'h5F; ld = 1'b0;
        en = 1'b0;
        clock_and_check("R6 no carry when en=0");
        chk("R6 upper nibble kept at 5", q[7:4], 4'h5);
    endtask

    task automatic t_terminal();
        ld = 1'b1; din = 8'hFF; step(); exp_q = 8'hFF; ld = 1'b0;
        en = 1'b0; #1;
        chk("R7 tc low at FF with en=0", tc, 0);
        en = 1'b1; #1;
        chk("R7 tc high at FF with en=1", tc, 1);
        clock_and_check("R8 FF wraps to 00");
        chk("R7 tc low after wrap", tc, 0);
        ld = 1'b1; din = 8'hFE; step(); exp_q = 8'hFE; ld = 1'b0; #1;
        chk("R7 tc low at FE", tc, 0);
    endtask

    task automatic t_full_cycle();
        int tc_hits;
        tc_hits = 0;
        ld = 1'b1; din = 8'h00; step(); exp_q = 8'h00; ld = 1'b0;
        en = 1'b1;
        for (int i = 0; i < 256; i++) begin
            if (tc) tc_hits++;
            exp_q = model_next(exp_q);
            step();
            if (q != exp_q) chk("R3 full cycle", q, exp_q);
        end
        chk("R8 back at 00 after 256 counts", q, 0);
        chk("R7 tc high exactly once per 256", tc_hits, 1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_load();
        t_hold();
        t_count_run();
        t_nibble_carry();
        t_terminal();
        t_full_cycle();
        clr = 1'b1;
        clock_and_check("R1 clear from running state");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule